// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sits beside the execute stage of a 32-bit processor core. Each clock it looks at the exception sources: the reset exception request, the undefined-instruction and software-interrupt traps, the two abort kinds and the two interrupt lines. It drops any interrupt line whose disable bit is set in the current status word, picks the highest-priority survivor, and one cycle later presents a complete entry packet. The packet holds the vector address, the new status word, the link value with the mode whose link register takes it, and a saved-status write strobe with its data. The core applies the packet in the cycle it is valid.

When no exception is eligible, the block accepts a return command. One cycle later it pulses a return strobe carrying the saved status word of the current mode, which the core copies back into the current status. Fetch, the register file and memory are handled outside this block.

A three-state machine drives the outputs. ST_IDLE means no packet, ST_ENTER means an entry packet is valid, and ST_RETURN means a return packet is valid. The next state is chosen the same way from every state:
- GO_ENTER is taken when any exception is eligible.
- GO_RETURN is taken when no exception is eligible and a return is requested.
- GO_IDLE is taken otherwise.

So back-to-back packets are possible.

Top module: `exc_sequencer`

## Requirements
- R1: While rst_n is low, and after it is released until the first packet, entry_valid, ret_valid and spsr_we are 0, and every data output is 0.
- R2: Inputs sampled at one rising edge produce their packet during the following cycle only. In any cycle with no entry packet, vec_addr, new_psr, link_value, link_mode, spsr_we and spsr_wdata read 0. In any cycle with no return packet, ret_psr reads 0.
- R3: Exceptions are ranked, highest first: boot_req, dabt_req, eligible fiq_req, eligible irq_req, pabt_req, und_req, swi_req. Only the highest-ranked one is entered.
- R4: The vectors are 0x00 for reset, 0x04 for undefined, 0x08 for software interrupt, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for normal interrupt and 0x1C for fast interrupt. 0x14 is never produced.
- R5: The entry modes use the 5-bit codes supervisor 0x13, abort 0x17, undefined 0x1B, normal interrupt 0x12 and fast interrupt 0x11. Reset and software interrupt enter supervisor, both aborts enter abort, undefined enters undefined, and each interrupt enters its own mode. link_mode and new_psr[4:0] both carry this code.
- R6: For every non-reset entry, the status word is built from the current one as follows. Bit 7 (normal-interrupt disable) is set to 1. Bit 6 (fast-interrupt disable) is set to 1 for the fast interrupt and copied otherwise. Bit 5 (state bit) is cleared to 0. Bits 31:8 are copied.
- R7: link_value is instr_addr+8 for a data abort and instr_addr+4 for every other non-reset exception.
- R8: Every non-reset entry pulses spsr_we with spsr_wdata equal to the cur_psr that was sampled.
- R9: irq_req is ignored while cur_psr[7] is 1, and fiq_req is ignored while cur_psr[6] is 1.
- R10: A reset entry gives vec_addr 0, new_psr 0x000000D3, link_mode 0x13, link_value 0, and spsr_we 0.
- R11: ret_req with no eligible exception pulses ret_valid in the next cycle, with ret_psr equal to the saved_psr that was sampled.
- R12: When ret_req and an eligible exception are sampled at the same edge, the entry is taken and the return command is dropped. entry_valid and ret_valid are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| boot_req | input | 1 | Reset exception request |
| und_req | input | 1 | Undefined-instruction trap |
| swi_req | input | 1 | Software-interrupt trap |
| pabt_req | input | 1 | Prefetch abort |
| dabt_req | input | 1 | Data abort |
| irq_req | input | 1 | Normal interrupt request (level) |
| fiq_req | input | 1 | Fast interrupt request (level) |
| ret_req | input | 1 | Exception return command |
| cur_psr | input | 32 | Current status word |
| instr_addr | input | 32 | Address of faulting or current instruction |
| saved_psr | input | 32 | Saved status word of the current mode |
| entry_valid | output | 1 | Entry packet valid |
| vec_addr | output | 32 | Vector address to fetch from |
| new_psr | output | 32 | Status word after entry |
| link_value | output | 32 | Value for the target mode's link register |
| link_mode | output | 5 | Mode whose link and saved status are written |
| spsr_we | output | 1 | Saved-status write strobe |
| spsr_wdata | output | 32 | Saved-status write data |
| ret_valid | output | 1 | Return packet valid |
| ret_psr | output | 32 | Status word to restore on return |

## Verification
The two functions that can land on the same edge are an exception entry and a return command. A directed case drives ret_req together with a software-interrupt trap and expects only the entry packet, with ret_valid at 0. Random stimulus raises ret_req on about a quarter of cycles, while each exception source fires independently at a low rate, so the collision also recurs many times, including cases where only a masked interrupt is present and the return must then go through. Every cycle's outputs are compared as a whole against a bench model of the priority and entry rules.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN      = 32;
    localparam int MODE_W    = 5;
    localparam int NUM_KINDS = 7;

    localparam int PSR_I = 7;
    localparam int PSR_F = 6;
    localparam int PSR_T = 5;

    localparam logic [MODE_W-1:0] MODE_FAST = 5'h11;
    localparam logic [MODE_W-1:0] MODE_NORM = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SUPV = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABRT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_UNDF = 5'h1B;

    // Index order is the priority order (0 = highest).
    typedef enum logic [2:0] {
        EXK_BOOT = 3'd0,
        EXK_DABT = 3'd1,
        EXK_FAST = 3'd2,
        EXK_NORM = 3'd3,
        EXK_PABT = 3'd4,
        EXK_UNDF = 3'd5,
        EXK_SWI  = 3'd6,
        EXK_NONE = 3'd7
    } exc_kind_e;

    typedef struct packed {
        logic [XLEN-1:0]   vec;
        logic [XLEN-1:0]   psr;
        logic [XLEN-1:0]   link;
        logic [MODE_W-1:0] mode;
        logic              save;
        logic [XLEN-1:0]   sdata;
    } entry_pkt_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ENTER  = 2'd1,
        ST_RETURN = 2'd2
    } seq_state_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
    parameter int N = 7
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            assign grant[i]  = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
        end
    endgenerate

    assign any = seen[N];
endmodule

// File: rtl/exc_entry_table.sv
module exc_entry_table
    import exc_pkg::*;
#(
    parameter int                N        = NUM_KINDS,
    parameter logic [XLEN-1:0]   VEC_BASE = '0
) (
    input  logic [N-1:0]    grant,
    input  logic [XLEN-1:0] cur_psr,
    input  logic [XLEN-1:0] instr_addr,
    output entry_pkt_t      pkt
);
    localparam logic [XLEN-1:0] BOOT_PSR = XLEN'(32'h0000_00D3);

    exc_kind_e       kind;
    logic [3:0]      offs;
    logic            set_f;
    logic [7:0]      vec_lo;
    logic [MODE_W-1:0] mode;

    always_comb begin
        kind = EXK_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (grant[i]) kind = exc_kind_e'(i);
        end
    end

    always_comb begin
        vec_lo = 8'h00;
        mode   = MODE_SUPV;
        offs   = 4'd4;
        set_f  = 1'b0;
        unique case (kind)
            EXK_BOOT: begin vec_lo = 8'h00; mode = MODE_SUPV; offs = 4'd0; set_f = 1'b1; end
            EXK_DABT: begin vec_lo = 8'h10; mode = MODE_ABRT; offs = 4'd8; end
            EXK_FAST: begin vec_lo = 8'h1C; mode = MODE_FAST; set_f = 1'b1; end
            EXK_NORM: begin vec_lo = 8'h18; mode = MODE_NORM; end
            EXK_PABT: begin vec_lo = 8'h0C; mode = MODE_ABRT; end
            EXK_UNDF: begin vec_lo = 8'h04; mode = MODE_UNDF; end
            EXK_SWI:  begin vec_lo = 8'h08; mode = MODE_SUPV; end
            EXK_NONE: begin vec_lo = 8'h00; mode = MODE_SUPV; end
        endcase
    end

    always_comb begin
        pkt.vec  = VEC_BASE + XLEN'(vec_lo);
        pkt.mode = mode;
        if (kind == EXK_BOOT) begin
            pkt.psr   = BOOT_PSR;
            pkt.link  = '0;
            pkt.save  = 1'b0;
            pkt.sdata = '0;
        end else begin
            pkt.psr        = cur_psr;
            pkt.psr[PSR_I] = 1'b1;
            pkt.psr[PSR_F] = cur_psr[PSR_F] | set_f;
            pkt.psr[PSR_T] = 1'b0;
            pkt.psr[MODE_W-1:0] = mode;
            pkt.link  = instr_addr + XLEN'(offs);
            pkt.save  = 1'b1;
            pkt.sdata = cur_psr;
        end
    end
endmodule

// File: rtl/exc_fsm.sv
module exc_fsm
    import exc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_exc,
    input  logic            ret_req,
    input  entry_pkt_t      pkt_in,
    input  logic [XLEN-1:0] saved_psr,
    output logic            entry_valid,
    output entry_pkt_t      pkt_out,
    output logic            ret_valid,
    output logic [XLEN-1:0] ret_psr
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ENTER, ST_RETURN: begin
                if (take_exc)     state_d = ST_ENTER;   // GO_ENTER
                else if (ret_req) state_d = ST_RETURN;  // GO_RETURN
                else              state_d = ST_IDLE;    // GO_IDLE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_out <= '0;
            ret_psr <= '0;
        end else begin
            unique case (state_d)
                ST_ENTER: begin
                    pkt_out <= pkt_in;
                    ret_psr <= '0;
                end
                ST_RETURN: begin
                    pkt_out <= '0;
                    ret_psr <= saved_psr;
                end
                default: begin
                    pkt_out <= '0;
                    ret_psr <= '0;
                end
            endcase
        end
    end

    assign entry_valid = (state_q == ST_ENTER);
    assign ret_valid   = (state_q == ST_RETURN);
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_req,
    input  logic              und_req,
    input  logic              swi_req,
    input  logic              pabt_req,
    input  logic              dabt_req,
    input  logic              irq_req,
    input  logic              fiq_req,
    input  logic              ret_req,
    input  logic [XLEN-1:0]   cur_psr,
    input  logic [XLEN-1:0]   instr_addr,
    input  logic [XLEN-1:0]   saved_psr,
    output logic              entry_valid,
    output logic [XLEN-1:0]   vec_addr,
    output logic [XLEN-1:0]   new_psr,
    output logic [XLEN-1:0]   link_value,
    output logic [MODE_W-1:0] link_mode,
    output logic              spsr_we,
    output logic [XLEN-1:0]   spsr_wdata,
    output logic              ret_valid,
    output logic [XLEN-1:0]   ret_psr
);
    logic [NUM_KINDS-1:0] pend;
    logic [NUM_KINDS-1:0] grant;
    logic                 any_exc;
    entry_pkt_t           pkt_c, pkt_q;

    always_comb begin
        pend             = '0;
        pend[EXK_BOOT]   = boot_req;
        pend[EXK_DABT]   = dabt_req;
        pend[EXK_FAST]   = fiq_req & ~cur_psr[PSR_F];
        pend[EXK_NORM]   = irq_req & ~cur_psr[PSR_I];
        pend[EXK_PABT]   = pabt_req;
        pend[EXK_UNDF]   = und_req;
        pend[EXK_SWI]    = swi_req;
    end

    exc_arbiter #(.N(NUM_KINDS)) u_arb (
        .req   (pend),
        .grant (grant),
        .any   (any_exc)
    );

    exc_entry_table #(.N(NUM_KINDS), .VEC_BASE(VEC_BASE)) u_tab (
        .grant      (grant),
        .cur_psr    (cur_psr),
        .instr_addr (instr_addr),
        .pkt        (pkt_c)
    );

    exc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_exc    (any_exc),
        .ret_req     (ret_req),
        .pkt_in      (pkt_c),
        .saved_psr   (saved_psr),
        .entry_valid (entry_valid),
        .pkt_out     (pkt_q),
        .ret_valid   (ret_valid),
        .ret_psr     (ret_psr)
    );

    assign vec_addr   = pkt_q.vec;
    assign new_psr    = pkt_q.psr;
    assign link_value = pkt_q.link;
    assign link_mode  = pkt_q.mode;
    assign spsr_we    = pkt_q.save;
    assign spsr_wdata = pkt_q.sdata;
endmodule

// File: rtl/exc_checker.sv
module exc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [6:0]  reqs,
    input logic        irq_mask,
    input logic        fiq_mask,
    input logic [31:0] saved_psr,
    input logic        entry_valid,
    input logic [31:0] vec_addr,
    input logic [7:0]  psr_lo,
    input logic [4:0]  link_mode,
    input logic        spsr_we,
    input logic        ret_valid,
    input logic [31:0] ret_psr
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // reqs = {boot, dabt, fiq, irq, pabt, und, swi}
    assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(entry_valid && ret_valid));

    assert_vec_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid |-> (vec_addr[1:0] == 2'b00 && vec_addr != 32'h14 && vec_addr <= 32'h1C));

    assert_entry_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid |-> (psr_lo[7] && !psr_lo[5]));

    assert_mode_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid |-> (psr_lo[4:0] == link_mode));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && entry_valid && vec_addr == 32'h18) |-> !$past(irq_mask));

    assert_fiq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && entry_valid && vec_addr == 32'h1C) |-> !$past(fiq_mask));

    assert_ret_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ret_valid) |-> (ret_psr == $past(saved_psr)));

    assert_boot_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(reqs[6])) |-> (entry_valid && vec_addr == 32'h0 && !spsr_we));

    assert_save_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && vec_addr != 32'h0) |-> spsr_we);

    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(reqs == 7'b0)) |-> !entry_valid);
endmodule

bind exc_sequencer exc_checker u_exc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqs        ({boot_req, dabt_req, fiq_req, irq_req, pabt_req, und_req, swi_req}),
    .irq_mask    (cur_psr[7]),
    .fiq_mask    (cur_psr[6]),
    .saved_psr   (saved_psr),
    .entry_valid (entry_valid),
    .vec_addr    (vec_addr),
    .psr_lo      (new_psr[7:0]),
    .link_mode   (link_mode),
    .spsr_we     (spsr_we),
    .ret_valid   (ret_valid),
    .ret_psr     (ret_psr)
);

// File: tb/tb_exc_sequencer.sv
`timescale 1ns/1ps
module tb_exc_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boot_req = 0, und_req = 0, swi_req = 0, pabt_req = 0, dabt_req = 0;
    logic irq_req = 0, fiq_req = 0, ret_req = 0;
    logic [31:0] cur_psr = '0, instr_addr = '0, saved_psr = '0;
    logic entry_valid, spsr_we, ret_valid;
    logic [31:0] vec_addr, new_psr, link_value, spsr_wdata, ret_psr;
    logic [4:0] link_mode;

    always #2 clk = ~clk;

    exc_sequencer dut (.*);

    typedef struct packed {
        logic        ev;
        logic [31:0] vec;
        logic [31:0] psr;
        logic [31:0] link;
        logic [4:0]  mode;
        logic        we;
        logic [31:0] wd;
        logic        rv;
        logic [31:0] rp;
    } obs_t;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    function automatic obs_t model(logic [6:0] r, logic ret, logic [31:0] p,
                                   logic [31:0] a, logic [31:0] sp);
        // r = {boot, dabt, fiq, irq, pabt, und, swi}
        obs_t o;
        logic [31:0] v;
        logic [4:0]  m;
        logic [31:0] l;
        logic        sf;
        logic        hit;
        o = '0; hit = 1'b1; sf = 1'b0; v = 0; m = 0; l = 0;
        if (r[6]) begin
            o.ev = 1; o.vec = 0; o.psr = 32'hD3; o.link = 0; o.mode = 5'h13;
            return o;
        end
        if (r[5])                 begin v = 32'h10; m = 5'h17; l = a + 8; end
        else if (r[4] && !p[6])   begin v = 32'h1C; m = 5'h11; l = a + 4; sf = 1; end
        else if (r[3] && !p[7])   begin v = 32'h18; m = 5'h12; l = a + 4; end
        else if (r[2])            begin v = 32'h0C; m = 5'h17; l = a + 4; end
        else if (r[1])            begin v = 32'h04; m = 5'h1B; l = a + 4; end
        else if (r[0])            begin v = 32'h08; m = 5'h13; l = a + 4; end
        else hit = 1'b0;
        if (hit) begin
            o.ev = 1; o.vec = v; o.link = l; o.mode = m; o.we = 1; o.wd = p;
            o.psr = {p[31:8], 1'b1, p[6] | sf, 1'b0, m};
        end else if (ret) begin
            o.rv = 1; o.rp = sp;
        end
        return o;
    endfunction

    function automatic obs_t sample();
        return '{entry_valid, vec_addr, new_psr, link_value, link_mode,
                 spsr_we, spsr_wdata, ret_valid, ret_psr};
    endfunction

    task automatic check(string tag, obs_t act, obs_t exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Starts and ends at a falling edge; inputs are seen at exactly one rising edge.
    task automatic apply(string tag, logic [6:0] r, logic ret, logic [31:0] p,
                         logic [31:0] a, logic [31:0] sp);
        obs_t e;
        {boot_req, dabt_req, fiq_req, irq_req, pabt_req, und_req, swi_req} = r;
        ret_req = ret; cur_psr = p; instr_addr = a; saved_psr = sp;
        e = model(r, ret, p, a, sp);
        @(posedge clk); #1;
        check(tag, sample(), e);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0BAD_5EED));
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1 in reset", sample(), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", sample(), '0);

        // R10 and R3: everything at once, reset wins
        apply("R10 R3 all pending", 7'h7F, 1'b1, 32'hF000_0010, 32'h100, 32'h55);
        // R3: data abort over both interrupts and traps
        apply("R3 dabt wins", 7'b0111111, 1'b0, 32'h0000_0010, 32'h2000, 32'h0);
        // R9: fast masked, normal enabled -> normal interrupt
        apply("R9 fiq masked", 7'b0011000, 1'b0, 32'h0000_0050, 32'h3000, 32'h0);
        // R9: normal masked only source -> nothing
        apply("R9 irq masked", 7'b0001000, 1'b0, 32'h0000_0090, 32'h3004, 32'h0);
        // R6: fast interrupt sets F, clears T
        apply("R6 fiq from thumb", 7'b0010000, 1'b0, 32'hA000_0030, 32'h4002, 32'h0);
        // R7: data abort link +8
        apply("R7 dabt link", 7'b0100000, 1'b0, 32'h0000_001F, 32'hFFFF_FFFC, 32'h0);
        // R4 R5: each trap alone
        apply("R4 R5 pabt", 7'b0000100, 1'b0, 32'h0000_0010, 32'h500, 32'h0);
        apply("R4 R5 und",  7'b0000010, 1'b0, 32'h0000_0010, 32'h504, 32'h0);
        apply("R4 R5 swi",  7'b0000001, 1'b0, 32'h0000_0010, 32'h508, 32'h0);
        // R2: packet lasts one cycle
        apply("R2 pulse ends", 7'b0, 1'b0, 32'h0, 32'h0, 32'h0);
        // R11: return alone
        apply("R11 return", 7'b0, 1'b1, 32'h0000_0012, 32'h0, 32'h6000_001F);
        // R12: return with a trap -> entry only
        apply("R12 collision", 7'b0000001, 1'b1, 32'h0000_0010, 32'h700, 32'h1234_5678);
        // R12 with masked interrupt: return proceeds
        apply("R12 masked irq", 7'b0001000, 1'b1, 32'h0000_0080, 32'h0, 32'hCAFE_0013);
        // R8: saved data equals current status
        apply("R8 save data", 7'b0000010, 1'b0, 32'h5A5A_A5D0, 32'h40, 32'h0);

        for (int i = 0; i < 800; i++) begin
            logic [6:0] r;
            for (int b = 0; b < 7; b++) r[b] = ($urandom_range(9) == 0);
            if ($urandom_range(3) != 0) r[6] = 1'b0;
            apply("R3-mix R8 R9 random", r, ($urandom_range(3) == 0),
                  $urandom(), $urandom() & 32'hFFFF_FFFC, $urandom());
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule